// File: doc/BRIEF.md
# System Tick Countdown Timer

A down-counting periodic timer with a 24-bit counter and four word-wide registers on a simple valid/write/address/data port. Software loads a reload value and sets the control bits. The counter then counts down from the reload value to zero. On reaching zero it sets a sticky count flag and, if interrupts are enabled, raises a one-cycle interrupt request. On the next tick it loads the reload value again. The counter can step on every clock, or only on clocks where an external reference tick input is high.

The count flag clears when software reads the control register. Any write to the current-value register restarts the count and clears the flag. A reload value of zero makes the timer stop by itself at its next expiry, which gives a one-shot mode. Changing the clock source while the timer runs restarts the count.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read zero and `tick_irq` is low.
- R2: The control register at offset 0x10 has run at bit 0, interrupt enable at bit 1, clock source at bit 2 and the count flag at bit 16. A write changes only bits [2:0]. The count flag and all other bits keep their values.
- R3: A read of the control register returns the count flag and clears it after the access. If an expiry happens in the same cycle, the flag stays set.
- R4: While running, the counter drops by one per tick. After it reaches zero, the next tick loads the reload value, so a full period is reload+1 ticks.
- R5: Expiry is the tick on which the counter reaches zero. It sets the count flag. `tick_irq` goes high for exactly one cycle, in the cycle after the expiry edge, and only if the interrupt-enable bit is 1.
- R6: If the reload value is zero at an expiry, the run bit clears by itself.
- R7: A write of any data to the current-value register at offset 0x18 loads the counter from the reload register and clears the count flag.
- R8: The current-value register reads zero while the run bit is 0.
- R9: With the clock-source bit at 0, the counter steps only on cycles where `tick_en` is high. With it at 1, the counter steps on every clock.
- R10: A control write that changes the clock-source bit while the timer runs restarts the count from the reload value.
- R11: The reload register (offset 0x14) and the current-value register are 24 bits wide. Bits [31:24] read zero and are ignored on write.
- R12: The calibration register at offset 0x1C reads the `CALIB_VAL` parameter, and writes to it have no effect.
- R13: A control write that sets the run bit from 0 to 1 loads the counter from the reload register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | External reference tick, one clock wide per tick |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid combinationally during a read access |
| tick_irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
The bench checks the counter value one tick before and one tick after zero. A design that reloads early, or that skips the zero tick, gives a period one tick short. It places a control-register read on the same cycle as an expiry; a design that lets the read win loses that expiry. It runs with reload zero, both from the running state and straight from enable. A design without the auto-stop keeps firing interrupts. It also changes the clock source while running and counts reference ticks that are spread apart. A design that ignores the restart or the tick qualifier reads a different current value.

// File: rtl/stick_pkg.sv
package stick_pkg;
   // register byte offsets (software decodes these)
   localparam int unsigned REG_CTRL   = 'h10;
   localparam int unsigned REG_RELOAD = 'h14;
   localparam int unsigned REG_CUR    = 'h18;
   localparam int unsigned REG_CALIB  = 'h1C;

   // control register bit positions
   localparam int unsigned BIT_RUN   = 0;
   localparam int unsigned BIT_INTEN = 1;
   localparam int unsigned BIT_CLK   = 2;
   localparam int unsigned BIT_FLAG  = 16;

   typedef struct packed {
      logic clk_core;
      logic inten;
      logic run;
   } ctrl_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_RELOAD,
      SEL_CUR,
      SEL_CALIB
   } reg_sel_e;
endpackage

// File: rtl/stick_bus_dec.sv
module stick_bus_dec
   import stick_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned CALIB_VAL = 0
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  ctrl_t             ctrl_q,
   input  logic              flag_q,
   input  logic [CNT_W-1:0]  reload_q,
   input  logic [CNT_W-1:0]  cnt_q,
   output logic              wr_ctrl,
   output logic              wr_reload,
   output logic              wr_cur,
   output logic              rd_ctrl,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [DATA_W-1:0] CALIB_WORD = DATA_W'(CALIB_VAL);

   reg_sel_e sel;

   always_comb begin
      sel = SEL_NONE;
      if (bus_valid) begin
         if (bus_addr == ADDR_W'(REG_CTRL))        sel = SEL_CTRL;
         else if (bus_addr == ADDR_W'(REG_RELOAD)) sel = SEL_RELOAD;
         else if (bus_addr == ADDR_W'(REG_CUR))    sel = SEL_CUR;
         else if (bus_addr == ADDR_W'(REG_CALIB))  sel = SEL_CALIB;
      end
   end

   assign wr_ctrl   = (sel == SEL_CTRL)   &&  bus_write;
   assign wr_reload = (sel == SEL_RELOAD) &&  bus_write;
   assign wr_cur    = (sel == SEL_CUR)    &&  bus_write;
   assign rd_ctrl   = (sel == SEL_CTRL)   && !bus_write;

   always_comb begin
      rdata = '0;
      if (!bus_write) begin
         unique case (sel)
            SEL_CTRL: begin
               rdata[BIT_RUN]   = ctrl_q.run;
               rdata[BIT_INTEN] = ctrl_q.inten;
               rdata[BIT_CLK]   = ctrl_q.clk_core;
               rdata[BIT_FLAG]  = flag_q;
            end
            SEL_RELOAD: rdata[CNT_W-1:0] = reload_q;
            SEL_CUR:    rdata[CNT_W-1:0] = ctrl_q.run ? cnt_q : '0;
            SEL_CALIB:  rdata = CALIB_WORD;
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/stick_tick_sel.sv
module stick_tick_sel #(
   parameter bit REF_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_core,
   input  logic tick_en,
   output logic adv
);
   logic ref_adv;

   generate
      if (REF_EDGE) begin : g_edge
         // reference input may be a level; step once per rising edge
         logic tick_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_d <= 1'b0;
            else        tick_d <= tick_en;
         end
         assign ref_adv = tick_en & ~tick_d;
      end else begin : g_level
         logic unused_tie;
         assign unused_tie = clk ^ rst_n;
         assign ref_adv    = tick_en;
      end
   endgenerate

   assign adv = clk_core ? 1'b1 : ref_adv;
endmodule

// File: rtl/stick_count.sv
module stick_count #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_zero;
   assign at_zero = (cnt_q == '0);

   // reaching zero, or sitting at zero with nothing to reload
   assign expire = step & ((cnt_q == ONE) | (at_zero & (reload_val == '0)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load)    cnt_q <= reload_val;
      else if (step) begin
         if (at_zero)   cnt_q <= reload_val;
         else           cnt_q <= cnt_q - ONE;
      end
   end

   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(reload_val));
   p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && at_zero) |=> cnt_q == $past(reload_val));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/stick_ctrl.sv
module stick_ctrl
   import stick_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_reload,
   input  logic             wr_cur,
   input  logic             rd_ctrl,
   input  logic [2:0]       wctrl,
   input  logic [CNT_W-1:0] wcnt,
   input  logic             adv,
   input  logic             expire,
   output ctrl_t            ctrl_q,
   output logic             flag_q,
   output logic [CNT_W-1:0] reload_q,
   output logic             irq_q,
   output logic             load,
   output logic             step
);
   logic w_run, w_clk, stop_wr, restart, autostop;

   assign w_run    = wctrl[BIT_RUN];
   assign w_clk    = wctrl[BIT_CLK];
   assign stop_wr  = wr_ctrl & ~w_run;
   // start from idle, or clock source switched while running
   assign restart  = wr_ctrl & w_run & (~ctrl_q.run | (w_clk != ctrl_q.clk_core));
   assign load     = wr_cur | restart;
   assign step     = ctrl_q.run & adv & ~load & ~stop_wr;
   assign autostop = expire & (reload_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         flag_q   <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run      <= w_run & ~autostop;
            ctrl_q.inten    <= wctrl[BIT_INTEN];
            ctrl_q.clk_core <= w_clk;
         end else if (autostop) begin
            ctrl_q.run <= 1'b0;
         end
         if (wr_reload) reload_q <= wcnt;
         if (wr_cur)       flag_q <= 1'b0;
         else if (expire)  flag_q <= 1'b1;
         else if (rd_ctrl) flag_q <= 1'b0;
         irq_q <= expire & ctrl_q.inten;
      end
   end

   p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
   p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> flag_q);
   p_autostop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && reload_q == '0) |=> !ctrl_q.run);
   p_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && !expire) |=> !flag_q);
   p_curclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cur |=> !flag_q);
   p_no_step_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.run |-> !expire);
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
   import stick_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned CALIB_VAL = 'h0000_2710,
   parameter bit          REF_EDGE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tick_irq
);
   generate
      if (DATA_W <= BIT_FLAG) begin : g_bad_data_w
         $error("DATA_W must hold the count flag bit");
      end
      if (CNT_W < 2 || CNT_W >= DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must be at least 2 and narrower than DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr_w
         $error("ADDR_W too small for the register offsets");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic             flag_q, irq_q, load, step, adv, expire;
   logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl;
   logic [CNT_W-1:0] reload_q, cnt_q;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

   stick_bus_dec #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)
   ) u_dec (
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .ctrl_q(ctrl_q), .flag_q(flag_q), .reload_q(reload_q), .cnt_q(cnt_q),
      .wr_ctrl(wr_ctrl), .wr_reload(wr_reload), .wr_cur(wr_cur),
      .rd_ctrl(rd_ctrl), .rdata(bus_rdata)
   );

   stick_tick_sel #(.REF_EDGE(REF_EDGE)) u_tsel (
      .clk(clk), .rst_n(rst_n), .clk_core(ctrl_q.clk_core),
      .tick_en(tick_en), .adv(adv)
   );

   stick_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(wr_ctrl), .wr_reload(wr_reload), .wr_cur(wr_cur), .rd_ctrl(rd_ctrl),
      .wctrl(bus_wdata[2:0]), .wcnt(bus_wdata[CNT_W-1:0]),
      .adv(adv), .expire(expire),
      .ctrl_q(ctrl_q), .flag_q(flag_q), .reload_q(reload_q), .irq_q(irq_q),
      .load(load), .step(step)
   );

   stick_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .load(load),
      .reload_val(reload_q), .cnt_q(cnt_q), .expire(expire)
   );

   assign tick_irq = irq_q;

   p_cur_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == ADDR_W'(REG_CUR) && !ctrl_q.run)
      |-> bus_rdata == '0);
endmodule

// File: tb/sys_tick_timer_tb_top.sv
`timescale 1ns/1ps
module sys_tick_timer_tb_top;
   localparam int unsigned CALIB = 'h0000_2710;
   localparam logic [11:0] A_CTRL = 12'h010, A_REL = 12'h014,
                           A_CUR = 12'h018, A_CAL = 12'h01C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sys_tick_timer #(.CALIB_VAL(CALIB)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
   );

   // op: 0 write, 1 read and compare, 2 idle for data cycles
   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{2'd0, A_REL,  32'hAB00_0005, 32'h0,        8'd11}, // R11 upper bits dropped
      '{2'd1, A_REL,  32'h0,         32'h5,        8'd11}, // R11
      '{2'd1, A_CUR,  32'h0,         32'h0,        8'd8 }, // R8 idle reads zero
      '{2'd0, A_CTRL, 32'hFFFF_FFF5, 32'h0,        8'd2 }, // R2 only [2:0] land, R13 start
      '{2'd1, A_CTRL, 32'h0,         32'h5,        8'd2 }, // R2
      '{2'd1, A_CUR,  32'h0,         32'h4,        8'd13}, // R13 loaded 5 then stepped
      '{2'd2, 12'h0,  32'd2,         32'h0,        8'd4 },
      '{2'd1, A_CUR,  32'h0,         32'h1,        8'd4 }, // R4
      '{2'd1, A_CUR,  32'h0,         32'h0,        8'd4 }, // R4 zero for one tick
      '{2'd1, A_CUR,  32'h0,         32'h5,        8'd4 }, // R4 reload after zero
      '{2'd1, A_CTRL, 32'h0,         32'h0001_0005,8'd5 }, // R5 flag set
      '{2'd1, A_CTRL, 32'h0,         32'h5,        8'd3 }, // R3 cleared by read
      '{2'd0, A_CUR,  32'hFFFF_FFFF, 32'h0,        8'd7 }, // R7 forced reload
      '{2'd1, A_CUR,  32'h0,         32'h5,        8'd7 }, // R7
      '{2'd0, A_CTRL, 32'h1,         32'h0,        8'd10}, // R10 source switch restarts
      '{2'd2, 12'h0,  32'd3,         32'h0,        8'd9 },
      '{2'd1, A_CUR,  32'h0,         32'h5,        8'd9 }, // R9 R10 no ref ticks
      '{2'd0, A_CTRL, 32'h0,         32'h0,        8'd8 },
      '{2'd1, A_CUR,  32'h0,         32'h0,        8'd8 }, // R8
      '{2'd1, A_CTRL, 32'h0,         32'h0,        8'd2 }, // R2
      '{2'd1, A_CAL,  32'h0,         CALIB,        8'd12}, // R12
      '{2'd0, A_CAL,  32'hFFFF_FFFF, 32'h0,        8'd12},
      '{2'd1, A_CAL,  32'h0,         CALIB,        8'd12}, // R12 write ignored
      '{2'd1, A_REL,  32'h0,         32'h5,        8'd12}  // R12 other regs untouched
   };

   task automatic check(input int req, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   // every task starts just after a falling edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic watch(input int n, output int cnt, output int first);
      cnt = 0; first = 0;
      for (int i = 1; i <= n; i++) begin
         @(posedge clk); @(negedge clk);
         if (tick_irq) begin
            cnt++;
            if (first == 0) first = i;
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all-R actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int n, f;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, d); check(1, d, 32'h0, "reset ctrl");
      rd(A_REL, d);  check(1, d, 32'h0, "reset reload");
      check(1, {31'b0, tick_irq}, 32'h0, "reset irq");

      for (int v = 0; v < NV; v++) begin
         case (VECS[v].op)
            2'd0: wr(VECS[v].addr, VECS[v].data);
            2'd1: begin
               rd(VECS[v].addr, d);
               check(int'(VECS[v].req), d, VECS[v].exp, $sformatf("vector %0d", v));
            end
            default: idle(int'(VECS[v].data));
         endcase
      end

      // R5 R4: interrupt pulses, period reload+1
      wr(A_REL, 32'd2);
      wr(A_CTRL, 32'h7);
      watch(6, n, f);
      check(5, n, 2, "irq pulse count");
      check(4, f, 2, "first expiry tick");

      // R2 write keeps the flag
      wr(A_CTRL, 32'hFFFF_0007);
      rd(A_CTRL, d); check(2, d, 32'h0001_0007, "flag kept on write");
      // R3 expiry in the same cycle as the read keeps the flag
      rd(A_CTRL, d); check(3, d, 32'h0001_0007, "flag set wins over read");
      rd(A_CTRL, d); check(3, d, 32'h7, "flag cleared");

      // R5 no request with interrupt enable low
      wr(A_CTRL, 32'h5);
      watch(6, n, f);
      check(5, n, 0, "irq masked");

      // R6 reload zero stops at next expiry
      wr(A_REL, 32'd0);
      watch(4, n, f);
      rd(A_CTRL, d); check(6, d, 32'h0001_0004, "auto stop");
      rd(A_CUR, d);  check(8, d, 32'h0, "stopped reads zero");

      // R6 R13 enable with reload zero gives a single shot
      wr(A_CTRL, 32'h7);
      watch(3, n, f);
      check(6, n, 1, "one shot irq");
      rd(A_CTRL, d); check(6, d, 32'h0001_0006, "one shot stopped");

      // R9 reference ticks only
      wr(A_REL, 32'd10);
      wr(A_CTRL, 32'h1);
      for (int i = 0; i < 8; i++) begin
         tick_en = (i % 3 == 0);
         @(posedge clk); @(negedge clk);
      end
      tick_en = 1'b0;
      rd(A_CUR, d); check(9, d, 32'd7, "reference ticks");

      // R1 reset again from a busy state
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_CTRL, d); check(1, d, 32'h0, "re-reset ctrl");
      rd(A_REL, d);  check(1, d, 32'h0, "re-reset reload");
      rd(A_CUR, d);  check(1, d, 32'h0, "re-reset current");
      check(1, {31'b0, tick_irq}, 32'h0, "re-reset irq");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule